// File: doc/BRIEF.md
# Packed Rounding Saturating Lane Shifter

This block shifts every 16-bit signed lane of a packed operand by one common signed amount. The amount is a small two's-complement field taken from the low bits of a second operand, and its sign selects the direction. A non-negative amount shifts each lane left at full precision and then clamps it to the signed 16-bit range. A negative amount shifts each lane right arithmetically and rounds the result to nearest, with halves going toward positive infinity. A right shift of sixteen is treated as a right shift of fifteen.

The packed result is captured in an output register whenever an operation is strobed. A sticky overflow flag records that some lane was clamped by a left shift. The flag stays set until it is explicitly cleared or the block is reset. The lane count follows the datapath width (XLEN/16). A parameter can remove the output register so the result becomes purely combinational.

Top module: `lane_shift_round_sat`

## Requirements
- R1: The operand `opd_a` holds XLEN/16 signed lanes, lane i in bits [16i+15:16i]. Every lane is shifted independently by the same amount, and no bit crosses a lane boundary.
- R2: The shift amount is `opd_b[4:0]` read as a signed value from -16 to +15. Bits of `opd_b` above bit 4 have no effect on the result or on the flag.
- R3: An amount of zero returns every lane unchanged.
- R4: For an amount of +1 to +15, each lane is shifted left at full precision. A lane result above 32767 becomes 0x7FFF and a result below -32768 becomes 0x8000; such a lane is said to saturate. A result of exactly -32768 is not saturation.
- R5: For an amount of -m with m from 1 to 15, each lane result is ((x >>> (m-1)) + 1) >>> 1, computed without wrap, so 0x7FFF shifted by -1 gives 0x4000.
- R6: An amount of -16 (`opd_b[4:0]` = 5'b10000) gives exactly the same result as -15.
- R7: When `op_en` is high and any lane saturates, `ovf_o` is 1 after the next clock edge and stays 1 while `ovf_clr` is low. A right shift never saturates a lane.
- R8: `ovf_clr` high clears `ovf_o` at the next edge. If a saturating operation is strobed in the same cycle, the flag is set instead.
- R9: With REGISTERED=1, `res_o` loads the shifted word at the clock edge where `op_en` is high and holds its value while `op_en` is low. A cycle with `op_en` low never sets the flag.
- R10: While `rst_n` is low at a clock edge, `res_o` becomes 0 and `ovf_o` becomes 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_en | input | 1 | Strobe: load the result and allow the flag to be set |
| ovf_clr | input | 1 | Clear the sticky overflow flag |
| opd_a | input | XLEN | Packed signed 16-bit lanes to shift |
| opd_b | input | XLEN | Low 5 bits give the signed shift amount |
| res_o | output | XLEN | Packed shifted lanes |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
Both the shifted word and the overflow flag are due at the first rising edge after the stimulus is presented with `op_en` high. The flag is also due at that edge after `ovf_clr`, and both outputs clear at the first edge with `rst_n` low. The bench changes inputs on falling edges and samples outputs one nanosecond after the following rising edge, so every check looks exactly one register stage after its stimulus. For the checks that something is held or left alone, the bench samples one edge after a cycle with `op_en` low and compares against the value captured before it.

// File: rtl/lsr_pkg.sv
`timescale 1ns/1ps
// Package: shared widths and the decoded shift-control type.
// Assumes a lane width that is a power of two.
package lsr_pkg;
    parameter int LANE_W = 16;
    localparam int SH_W  = $clog2(LANE_W);   // bits of a shift magnitude
    localparam int AMT_W = SH_W + 1;         // signed amount field width

    typedef struct packed {
        logic            go_left;  // amount is zero or positive
        logic [SH_W-1:0] shl;      // left shift count
        logic [SH_W-1:0] shr_pre;  // right magnitude minus one, after clamp
    } shift_ctrl_t;
endpackage

// File: rtl/lsr_amt_decode.sv
`timescale 1ns/1ps
// Module: turns the signed amount field into a direction and counts.
// A negative magnitude of LANE_W is clamped to LANE_W-1.
// Assumes amt is a two's-complement value of AMT_W bits.
module lsr_amt_decode
    import lsr_pkg::*;
(
    input  logic [AMT_W-1:0] amt,
    output shift_ctrl_t      ctrl
);
    logic [AMT_W-1:0] mag;
    logic [SH_W-1:0]  mag_c;

    // Negate, clamp and pre-decrement the right magnitude.
    always_comb begin
        mag   = -amt;
        mag_c = mag[SH_W] ? {SH_W{1'b1}} : mag[SH_W-1:0];
        ctrl.go_left = ~amt[AMT_W-1];
        ctrl.shl     = amt[SH_W-1:0];
        ctrl.shr_pre = mag_c - SH_W'(1);
    end
endmodule

// File: rtl/lsr_lane.sv
`timescale 1ns/1ps
// Module: one signed lane. Either a full-precision left shift with
// saturation, or a rounding arithmetic right shift.
// Assumes ctrl comes from lsr_amt_decode (shr_pre < LANE_W-1).
module lsr_lane
    import lsr_pkg::*;
(
    input  logic [LANE_W-1:0] x,
    input  shift_ctrl_t       ctrl,
    output logic [LANE_W-1:0] y,
    output logic              sat
);
    localparam int WIDE_W = 2 * LANE_W;
    localparam int EXT_W  = LANE_W + 2;
    localparam logic signed [WIDE_W-1:0] POS_LIM = WIDE_W'((64'd1 << (LANE_W-1)) - 64'd1);
    localparam logic signed [WIDE_W-1:0] NEG_LIM = -POS_LIM - WIDE_W'(1);

    logic signed [WIDE_W-1:0] wide;
    logic signed [EXT_W-1:0]  ext, pre, sum, rnd;

    // Left path at double width, right path two bits wider than a lane.
    always_comb begin
        wide = {{LANE_W{x[LANE_W-1]}}, x} <<< ctrl.shl;
        ext  = {{2{x[LANE_W-1]}}, x};
        pre  = ext >>> ctrl.shr_pre;
        sum  = pre + EXT_W'(1);
        rnd  = sum >>> 1;
    end

    // Pick direction and clamp the left result.
    always_comb begin
        sat = 1'b0;
        if (!ctrl.go_left) begin
            y = rnd[LANE_W-1:0];
        end else if (wide > POS_LIM) begin
            y   = {1'b0, {(LANE_W-1){1'b1}}};
            sat = 1'b1;
        end else if (wide < NEG_LIM) begin
            y   = {1'b1, {(LANE_W-1){1'b0}}};
            sat = 1'b1;
        end else begin
            y = wide[LANE_W-1:0];
        end
    end
endmodule

// File: rtl/lane_shift_round_sat.sv
`timescale 1ns/1ps
// Module: top. Applies one signed amount to every lane, keeps a sticky
// overflow flag and, when REGISTERED=1, registers the packed result.
// Assumes XLEN is a multiple of the lane width.
module lane_shift_round_sat
    import lsr_pkg::*;
#(
    parameter int XLEN       = 64,
    parameter bit REGISTERED = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_en,
    input  logic            ovf_clr,
    input  logic [XLEN-1:0] opd_a,
    input  logic [XLEN-1:0] opd_b,
    output logic [XLEN-1:0] res_o,
    output logic            ovf_o
);
    localparam int NLANES = XLEN / LANE_W;

    shift_ctrl_t       ctrl;
    logic [XLEN-1:0]   res_c;
    logic [NLANES-1:0] lane_sat;
    logic              any_sat;
    logic              unused_hi;
    logic              ovf_q;

    assign unused_hi = ^opd_b[XLEN-1:AMT_W];

    lsr_amt_decode u_dec (.amt(opd_b[AMT_W-1:0]), .ctrl(ctrl));

    for (genvar i = 0; i < NLANES; i++) begin : g_lane
        lsr_lane u_lane (
            .x   (opd_a[i*LANE_W +: LANE_W]),
            .ctrl(ctrl),
            .y   (res_c[i*LANE_W +: LANE_W]),
            .sat (lane_sat[i])
        );
    end

    assign any_sat = |lane_sat;

    // Sticky flag: a saturation in the current operation beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) ovf_q <= 1'b0;
        else        ovf_q <= (ovf_q & ~ovf_clr) | (op_en & any_sat);
    end
    assign ovf_o = ovf_q;

    if (REGISTERED) begin : g_reg
        logic [XLEN-1:0] res_q;
        // Capture the packed result on each strobed operation.
        always_ff @(posedge clk) begin
            if (!rst_n)     res_q <= '0;
            else if (op_en) res_q <= res_c;
        end
        assign res_o = res_q;
    end else begin : g_comb
        assign res_o = res_c;
    end
endmodule

// File: rtl/lsr_checker.sv
`timescale 1ns/1ps
// Module: property checker for lane_shift_round_sat, attached by bind.
module lsr_checker #(
    parameter int XLEN       = 64,
    parameter bit REGISTERED = 1'b1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            op_en,
    input logic            ovf_clr,
    input logic [XLEN-1:0] opd_a,
    input logic [XLEN-1:0] opd_b,
    input logic            any_sat,
    input logic [XLEN-1:0] res_o,
    input logic            ovf_o
);
    // R10: reset empties the flag.
    assert_reset_flag_R10: assert property (@(posedge clk)
        !rst_n |=> !ovf_o);

    // R7: a strobed saturation sets the flag.
    assert_sat_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_en && any_sat) |=> ovf_o);

    // R7: the flag is sticky while no clear is requested.
    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !ovf_clr) |=> ovf_o);

    // R7: negative amounts never saturate a lane.
    assert_right_no_sat_R7: assert property (@(posedge clk) disable iff (!rst_n)
        opd_b[4] |-> !any_sat);

    // R8: a clear without a saturating operation empties the flag.
    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_clr && !(op_en && any_sat)) |=> !ovf_o);

    if (REGISTERED) begin : g_reg_chk
        // R10: reset empties the result register.
        assert_reset_res_R10: assert property (@(posedge clk)
            !rst_n |=> (res_o == '0));

        // R9: no strobe, no change of the result.
        assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !op_en |=> $stable(res_o));

        // R3: amount zero passes the operand through.
        assert_zero_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (op_en && opd_b[4:0] == 5'd0) |=> (res_o == $past(opd_a)));
    end
endmodule

bind lane_shift_round_sat lsr_checker #(.XLEN(XLEN), .REGISTERED(REGISTERED)) chk_i (
    .clk(clk), .rst_n(rst_n), .op_en(op_en), .ovf_clr(ovf_clr),
    .opd_a(opd_a), .opd_b(opd_b), .any_sat(any_sat),
    .res_o(res_o), .ovf_o(ovf_o)
);

// File: tb/lane_shift_round_sat_tb_top.sv
`timescale 1ns/1ps
// Bench: table-driven lane vectors, a sweep of all 32 amounts against a
// model of the requirements, then directed flag, hold and reset tests.
module lane_shift_round_sat_tb_top;
    localparam int XLEN = 64;
    localparam int NL   = XLEN / 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            op_en = 1'b0;
    logic            ovf_clr = 1'b0;
    logic [XLEN-1:0] opd_a = '0;
    logic [XLEN-1:0] opd_b = '0;
    logic [XLEN-1:0] res_o;
    logic            ovf_o;

    int n_checks = 0;
    int n_errors = 0;

    always #4 clk = ~clk;   // 125 MHz

    lane_shift_round_sat #(.XLEN(XLEN), .REGISTERED(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .op_en(op_en), .ovf_clr(ovf_clr),
        .opd_a(opd_a), .opd_b(opd_b), .res_o(res_o), .ovf_o(ovf_o)
    );

    // {lane in, amount, lane out, saturates}
    localparam logic [37:0] VEC [14] = '{
        {16'h1234, 5'h00, 16'h1234, 1'b0},   // R3
        {16'h0001, 5'h0F, 16'h7FFF, 1'b1},   // R4
        {16'h0001, 5'h0E, 16'h4000, 1'b0},   // R4
        {16'hFFFF, 5'h0F, 16'h8000, 1'b0},   // R4 exact minimum
        {16'h8000, 5'h01, 16'h8000, 1'b1},   // R4
        {16'h0100, 5'h07, 16'h7FFF, 1'b1},   // R4
        {16'hFF00, 5'h07, 16'h8000, 1'b0},   // R4
        {16'h7FFF, 5'h1F, 16'h4000, 1'b0},   // R5 no wrap
        {16'h8000, 5'h1F, 16'hC000, 1'b0},   // R5
        {16'h0003, 5'h1E, 16'h0001, 1'b0},   // R5
        {16'hFFFA, 5'h1E, 16'hFFFF, 1'b0},   // R5 half up
        {16'h0002, 5'h1E, 16'h0001, 1'b0},   // R5
        {16'h7FFF, 5'h10, 16'h0001, 1'b0},   // R6
        {16'h7FFF, 5'h11, 16'h0001, 1'b0}    // R6
    };

    localparam logic [15:0] EDGE_V [4] = '{16'h8000, 16'h7FFF, 16'h0000, 16'hFFFF};

    // Model of one lane from R3..R6: {saturates, result}.
    function automatic logic [16:0] ref_lane(logic [15:0] x, logic [4:0] amt);
        int v, s, m;
        v = int'($signed(x));
        if (!amt[4]) begin
            s = v << amt[3:0];
            if (s > 32767)  return {1'b1, 16'h7FFF};
            if (s < -32768) return {1'b1, 16'h8000};
            return {1'b0, s[15:0]};
        end
        m = 32 - int'(amt);
        if (m == 16) m = 15;
        s = ((v >>> (m - 1)) + 1) >>> 1;
        return {1'b0, s[15:0]};
    endfunction

    task automatic check(string tag, logic [XLEN-1:0] got, logic [XLEN-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Drive on the falling edge, sample 1 ns after the next rising edge.
    task automatic step(logic [XLEN-1:0] a, logic [XLEN-1:0] b, logic en, logic clr);
        @(negedge clk);
        opd_a = a; opd_b = b; op_en = en; ovf_clr = clr;
        @(posedge clk);
        #1;
    endtask

    task automatic run_model(string tag, logic [XLEN-1:0] a, logic [XLEN-1:0] b);
        logic [XLEN-1:0] exp;
        logic            sat;
        logic [16:0]     r;
        sat = 1'b0;
        for (int i = 0; i < NL; i++) begin
            r = ref_lane(a[i*16 +: 16], b[4:0]);
            exp[i*16 +: 16] = r[15:0];
            sat |= r[16];
        end
        step(a, b, 1'b1, 1'b1);
        check({tag, " result"}, res_o, exp);
        check({tag, " flag"}, XLEN'(ovf_o), XLEN'(sat));
    endtask

    initial begin
        logic [XLEN-1:0] a, held;
        // R10: reset state
        repeat (3) @(posedge clk);
        #1;
        check("R10 reset result", res_o, '0);
        check("R10 reset flag", XLEN'(ovf_o), '0);
        @(negedge clk);
        rst_n = 1'b1;

        // R3..R6, R1: table vectors replicated in every lane
        for (int k = 0; k < 14; k++) begin
            step({NL{VEC[k][37:22]}}, XLEN'(VEC[k][21:17]), 1'b1, 1'b1);
            check("R1 table result", res_o, {NL{VEC[k][16:1]}});
            check("R7 table flag", XLEN'(ovf_o), XLEN'(VEC[k][0]));
        end

        // R1, R2, R4, R5, R6: every amount, edge values rotated and random lanes
        for (int amt = 0; amt < 32; amt++) begin
            for (int rot = 0; rot < 4; rot++) begin
                for (int i = 0; i < NL; i++) a[i*16 +: 16] = EDGE_V[(i + rot) % 4];
                run_model("R1 edge sweep", a, XLEN'(amt));
            end
            for (int n = 0; n < 6; n++) begin
                a = {$urandom, $urandom};
                run_model("R5 random sweep", a, {$urandom, $urandom} & ~XLEN'(31) | XLEN'(amt));
            end
        end

        // R1: lanes independent, mixed saturation in one word
        step({16'h0001, 16'hFFFF, 16'h4000, 16'h0000}, XLEN'(2), 1'b1, 1'b1);
        check("R1 mixed lanes", res_o, {16'h0004, 16'hFFFC, 16'h7FFF, 16'h0000});

        // R2: upper bits of opd_b ignored
        step({NL{16'h0100}}, {{(XLEN-5){1'b1}}, 5'h01}, 1'b1, 1'b1);
        check("R2 upper bits ignored", res_o, {NL{16'h0200}});
        check("R2 flag untouched", XLEN'(ovf_o), '0);

        // R7: set, then sticky over a clean operation
        step({NL{16'h4000}}, XLEN'(1), 1'b1, 1'b0);
        check("R7 set", XLEN'(ovf_o), XLEN'(1));
        step({NL{16'h0001}}, XLEN'(1), 1'b1, 1'b0);
        check("R7 sticky", XLEN'(ovf_o), XLEN'(1));
        // R8: clear alone
        step('0, '0, 1'b0, 1'b1);
        check("R8 clear", XLEN'(ovf_o), '0);
        // R9: no strobe means no load and no flag
        held = res_o;
        step({NL{16'h7FFF}}, XLEN'(15), 1'b0, 1'b0);
        check("R9 hold result", res_o, held);
        check("R9 no flag", XLEN'(ovf_o), '0);
        // R8: saturation with clear in the same cycle wins
        step({NL{16'h7FFF}}, XLEN'(15), 1'b1, 1'b1);
        check("R8 set beats clear", XLEN'(ovf_o), XLEN'(1));
        // R7: right shift of extremes does not set the flag
        step('0, '0, 1'b0, 1'b1);
        step({NL{16'h8000}}, XLEN'(5'h10), 1'b1, 1'b0);
        check("R7 right no flag", XLEN'(ovf_o), '0);
        check("R6 clamp extreme", res_o, {NL{16'hFFFF}});

        // R10: reset in mid run
        step({NL{16'h7FFF}}, XLEN'(15), 1'b1, 1'b0);
        @(negedge clk);
        rst_n = 1'b0; op_en = 1'b0;
        @(posedge clk);
        #1;
        check("R10 mid reset result", res_o, '0);
        check("R10 mid reset flag", XLEN'(ovf_o), '0);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(8 * 150000);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule